// File: doc/BRIEF.md
# S/PDIF Sample-Rate Mode Detector

This block watches a raw biphase-mark coded serial audio line and decides which of seven standard sample rates it carries. Running on a reference clock, it measures the shortest time between two transitions of the line within a measurement window. A biphase-mark line is never shorter than half a bit cell, so this shortest interval is a direct measure of the line rate. At the end of each window the doubled interval is compared against six thresholds programmed by software, and the result is reported as a mode number next to the measured width.

Software fills in a small register file through a write/read port. The registers hold the enable, the window length, an interrupt enable mask, the per-mode half-cell timer values and the per-mode decision thresholds. The timers and thresholds are packed several to a 32-bit word. A sticky interrupt status bit is set whenever the reported mode differs from the one before, and is cleared by writing a one to it. Mode numbers 0 to 6 stand for 32 kHz, 44.1 kHz, 48 kHz, 88.2 kHz, 96 kHz, 176.4 kHz and 192 kHz. Mode 7 means that no signal is present.

Top module: `spdrate_detect`

## Requirements
- R1: After reset, mode_o is 7, minw_o is 0, irq_o is low and all registers read 0.
- R2: At the end of a window, the mode reported is the lowest i in 0..5 for which twice the minimum interval is greater than or equal to threshold i. Equality selects that mode.
- R3: When intervals were measured but no threshold is met, the mode reported is 6.
- R4: A window in which no complete edge-to-edge interval was measured reports minw_o = 0 and mode 7. Outside reset, minw_o is 0 exactly when mode_o is 7.
- R5: minw_o is the shortest interval, in reference-clock cycles, between consecutive edges of the synchronised line seen during the window, saturating at 1023. The window lasts WIN[19:0] cycles, and the outputs change only at a window end.
- R6: Threshold i (10 bits) lives in word THR+(i/3) at bit position 10*(2-(i%3)), so mode 0 sits in bits [29:20] of word THR. The addresses are THR0 = 4 and THR1 = 5.
- R7: Timer i (8 bits) lives in word TMR+(i/4) at bit position 8*(3-(i%4)). The addresses are TMR0 = 2 and TMR1 = 3, and every word reads back what was written.
- R8: Interrupt status (address 6) bit 2 is set at a window end whose mode differs from the previous mode. It is never set when the mode is unchanged, and writing 1 to bit 2 clears it. No other status bit is ever set.
- R9: irq_o is the OR of the status bits ANDed with the enable bits WIN[27:20] (address 1).
- R10: CTRL (address 0) bit 0 enables the detector. While it is 0, the window, interval and minimum counters stay at their reset values and mode_o and minw_o hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Raw biphase-mark serial line, asynchronous |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| mode_o | output | 3 | Detected mode, 7 = no signal |
| minw_o | output | 10 | Measured minimum edge interval |
| irq_o | output | 1 | Interrupt request |

## Verification
The checker watches several things on every cycle. It confirms that the reported width and mode agree on the no-signal case and that both outputs stay still between window ends and while the detector is disabled. It also confirms that the status bit only rises together with a change of mode, that no other status bit moves, and that the request line never rises without that status bit. What only the directed scenarios can show is the correctness of the result itself. This covers the selected mode for each line rate, the equality boundary of a threshold, the fallback to mode 6, the minimum of a mixed pattern, the packed field positions and the masking of the request line.

// File: rtl/spdrate_pkg.sv
package spdrate_pkg;
  localparam int MODES        = 7;
  localparam int MODE_W       = 3;
  typedef logic [MODE_W-1:0] mode_t;
  localparam mode_t MODE_NONE = mode_t'(MODES);
  localparam int IRQ_MODE_BIT = 2;
endpackage

// File: rtl/spdrate_sync_edge.sv
module spdrate_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic edge_o
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], line_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign edge_o = sh_q[STAGES-1] ^ sh_q[STAGES];
endmodule

// File: rtl/spdrate_width_meas.sv
module spdrate_width_meas #(
  parameter int WIN_W = 20,
  parameter int MW    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             edge_i,
  input  logic [WIN_W-1:0] win_len,
  output logic             win_end_o,
  output logic             got_o,
  output logic [MW-1:0]    minw_o
);
  localparam logic [MW-1:0] SAT = '1;

  logic [WIN_W-1:0] win_q, win_d;
  logic [MW-1:0]    run_q, run_d, min_q, min_d, min_now;
  logic             got_q, got_d, prev_q, prev_d, got_now, meas, win_end;

  always_comb begin
    meas    = edge_i & prev_q;
    min_now = (meas && (run_q < min_q)) ? run_q : min_q;
    got_now = got_q | meas;
    win_end = en && (({1'b0, win_q} + 1'b1) >= {1'b0, win_len});

    win_d  = '0;
    run_d  = '0;
    min_d  = SAT;
    got_d  = 1'b0;
    prev_d = 1'b0;
    if (en) begin
      run_d  = edge_i ? MW'(1) : ((run_q == SAT) ? run_q : run_q + 1'b1);
      prev_d = prev_q | edge_i;
      if (!win_end) begin
        win_d = win_q + 1'b1;
        min_d = min_now;
        got_d = got_now;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      run_q  <= '0;
      min_q  <= SAT;
      got_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      win_q  <= win_d;
      run_q  <= run_d;
      min_q  <= min_d;
      got_q  <= got_d;
      prev_q <= prev_d;
    end
  end

  assign win_end_o = win_end;
  assign got_o     = got_now;
  assign minw_o    = min_now;
endmodule

// File: rtl/spdrate_classify.sv
module spdrate_classify
  import spdrate_pkg::*;
#(
  parameter int MW    = 10,
  parameter int THR_W = 10
) (
  input  logic                         valid,
  input  logic [MW-1:0]                minw,
  input  logic [(MODES-1)*THR_W-1:0]   thr_flat,
  output mode_t                        mode
);
  localparam int CW = ((MW + 1) > THR_W) ? (MW + 2) : (THR_W + 1);

  logic [MODES-2:0] hit;
  logic [CW-1:0]    twice;

  assign twice = CW'({minw, 1'b0});

  for (genvar i = 0; i < MODES - 1; i++) begin : g_cmp
    assign hit[i] = twice >= CW'(thr_flat[i*THR_W +: THR_W]);
  end

  always_comb begin
    mode = mode_t'(MODES - 1);
    for (int i = MODES - 2; i >= 0; i--) begin
      if (hit[i]) mode = mode_t'(i);
    end
    if (!valid) mode = MODE_NONE;
  end
endmodule

// File: rtl/spdrate_detect.sv
module spdrate_detect
  import spdrate_pkg::*;
#(
  parameter int WIN_W = 20,
  parameter int MW    = 10,
  parameter int TMR_W = 8,
  parameter int THR_W = 10,
  parameter int IRQ_W = 8,
  parameter int AW    = 3,
  parameter int DW    = 32
) (
  input  logic          clk_ref,
  input  logic          rst_n,
  input  logic          line_in,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output mode_t         mode_o,
  output logic [MW-1:0] minw_o,
  output logic          irq_o
);
  localparam int TMR_PER  = DW / TMR_W;
  localparam int THR_PER  = DW / THR_W;
  localparam int TMR_REGS = (MODES + TMR_PER - 1) / TMR_PER;
  localparam int THR_REGS = (MODES - 1 + THR_PER - 1) / THR_PER;
  localparam int A_CTRL   = 0;
  localparam int A_WIN    = 1;
  localparam int A_TMR    = 2;
  localparam int A_THR    = A_TMR + TMR_REGS;
  localparam int A_IRQ    = A_THR + THR_REGS;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_q;
  logic       rst_n_s;
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_s = rst_q[1];

  // register file
  logic [DW-1:0]    ctrl_q, ctrl_d, win_q, win_d;
  logic [DW-1:0]    tmr_q [TMR_REGS];
  logic [DW-1:0]    tmr_d [TMR_REGS];
  logic [DW-1:0]    thr_q [THR_REGS];
  logic [DW-1:0]    thr_d [THR_REGS];
  logic [IRQ_W-1:0] irq_st_q, irq_st_d, irq_set, irq_clr;
  mode_t            mode_q, mode_d, cls_mode;
  logic [MW-1:0]    minw_q, minw_d, min_now;
  logic             edge_s, win_end, got;
  logic [(MODES-1)*THR_W-1:0] thr_flat;

  spdrate_sync_edge #(.STAGES(2)) u_sync (
    .clk(clk_ref), .rst_n(rst_n_s), .line_in(line_in), .edge_o(edge_s)
  );

  spdrate_width_meas #(.WIN_W(WIN_W), .MW(MW)) u_meas (
    .clk(clk_ref), .rst_n(rst_n_s), .en(ctrl_q[0]), .edge_i(edge_s),
    .win_len(win_q[WIN_W-1:0]), .win_end_o(win_end), .got_o(got),
    .minw_o(min_now)
  );

  for (genvar i = 0; i < MODES - 1; i++) begin : g_thr
    localparam int WRD = i / THR_PER;
    localparam int SH  = THR_W * (THR_PER - 1 - (i % THR_PER));
    assign thr_flat[i*THR_W +: THR_W] = thr_q[WRD][SH +: THR_W];
  end

  spdrate_classify #(.MW(MW), .THR_W(THR_W)) u_cls (
    .valid(got), .minw(min_now), .thr_flat(thr_flat), .mode(cls_mode)
  );

  always_comb begin
    ctrl_d = (cfg_we && cfg_addr == AW'(A_CTRL)) ? cfg_wdata : ctrl_q;
    win_d  = (cfg_we && cfg_addr == AW'(A_WIN))  ? cfg_wdata : win_q;
    for (int k = 0; k < TMR_REGS; k++)
      tmr_d[k] = (cfg_we && cfg_addr == AW'(A_TMR + k)) ? cfg_wdata : tmr_q[k];
    for (int k = 0; k < THR_REGS; k++)
      thr_d[k] = (cfg_we && cfg_addr == AW'(A_THR + k)) ? cfg_wdata : thr_q[k];

    mode_d = win_end ? cls_mode : mode_q;
    minw_d = win_end ? (got ? min_now : '0) : minw_q;

    irq_set = '0;
    irq_set[IRQ_MODE_BIT] = win_end && (cls_mode != mode_q);
    irq_clr = (cfg_we && cfg_addr == AW'(A_IRQ)) ? cfg_wdata[IRQ_W-1:0] : '0;
    irq_st_d = (irq_st_q & ~irq_clr) | irq_set;
  end

  always_ff @(posedge clk_ref or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ctrl_q   <= '0;
      win_q    <= '0;
      for (int k = 0; k < TMR_REGS; k++) tmr_q[k] <= '0;
      for (int k = 0; k < THR_REGS; k++) thr_q[k] <= '0;
      irq_st_q <= '0;
      mode_q   <= MODE_NONE;
      minw_q   <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      win_q    <= win_d;
      for (int k = 0; k < TMR_REGS; k++) tmr_q[k] <= tmr_d[k];
      for (int k = 0; k < THR_REGS; k++) thr_q[k] <= thr_d[k];
      irq_st_q <= irq_st_d;
      mode_q   <= mode_d;
      minw_q   <= minw_d;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == AW'(A_CTRL)) cfg_rdata = ctrl_q;
    if (cfg_addr == AW'(A_WIN))  cfg_rdata = win_q;
    for (int k = 0; k < TMR_REGS; k++)
      if (cfg_addr == AW'(A_TMR + k)) cfg_rdata = tmr_q[k];
    for (int k = 0; k < THR_REGS; k++)
      if (cfg_addr == AW'(A_THR + k)) cfg_rdata = thr_q[k];
    if (cfg_addr == AW'(A_IRQ)) cfg_rdata = DW'(irq_st_q);
  end

  assign mode_o = mode_q;
  assign minw_o = minw_q;
  assign irq_o  = |(irq_st_q & win_q[WIN_W +: IRQ_W]);
endmodule

// File: rtl/spdrate_detect_chk.sv
module spdrate_detect_chk
  import spdrate_pkg::*;
#(
  parameter int MW    = 10,
  parameter int IRQ_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             win_end,
  input mode_t            mode,
  input logic [MW-1:0]    minw,
  input logic [IRQ_W-1:0] irq_st,
  input logic             irq
);
  localparam logic [IRQ_W-1:0] OTHER_BITS = ~(IRQ_W'(1) << IRQ_MODE_BIT);

  assert_nosig_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (minw == '0) == (mode == MODE_NONE));

  assert_status_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> ($stable(mode) && $stable(minw)));

  assert_irq_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_st[IRQ_MODE_BIT] && !$past(irq_st[IRQ_MODE_BIT])) |-> (mode != $past(mode)));

  assert_only_mode_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_st & OTHER_BITS) == '0);

  assert_irq_needs_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_st[IRQ_MODE_BIT]);

  assert_disabled_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(mode) && $stable(minw)));
endmodule

bind spdrate_detect spdrate_detect_chk u_chk (
  .clk(clk_ref), .rst_n(rst_n_s), .en(ctrl_q[0]), .win_end(win_end),
  .mode(mode_q), .minw(minw_q), .irq_st(irq_st_q), .irq(irq_o)
);

// File: tb/spdrate_detect_tb_top.sv
module spdrate_detect_tb_top;
  logic        clk_ref = 1'b0;
  logic        rst_n;
  logic        line_in;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [2:0]  mode_o;
  logic [9:0]  minw_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  int half_a = 0;
  int half_b = 0;
  int tmr_v [7] = '{60, 44, 40, 22, 20, 11, 10};
  localparam int WIN = 200;

  always #5 clk_ref = ~clk_ref;

  spdrate_detect dut_i (
    .clk_ref(clk_ref), .rst_n(rst_n), .line_in(line_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mode_o(mode_o), .minw_o(minw_o), .irq_o(irq_o)
  );

  // line generator: intervals alternate half_a and half_b cycles, 0 = idle
  initial begin
    int cnt = 0;
    bit alt = 1'b0;
    line_in = 1'b0;
    forever begin
      @(negedge clk_ref);
      if (half_a != 0) begin
        cnt++;
        if (cnt >= (alt ? half_b : half_a)) begin
          line_in = ~line_in;
          cnt = 0;
          alt = ~alt;
        end
      end else cnt = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int thr_of(input int i);
    return tmr_v[i] + tmr_v[i+1];
  endfunction

  function automatic int exp_mode(input int h);
    for (int i = 0; i < 6; i++) if (2 * h >= thr_of(i)) return i;
    return 6;
  endfunction

  function automatic logic [31:0] thr_word(input int w);
    logic [31:0] v = '0;
    for (int i = 0; i < 6; i++)
      if (i / 3 == w) v |= 32'(thr_of(i)) << (10 * (2 - (i % 3)));
    return v;
  endfunction

  function automatic logic [31:0] tmr_word(input int w);
    logic [31:0] v = '0;
    for (int i = 0; i < 7; i++)
      if (i / 4 == w) v |= 32'(tmr_v[i]) << (8 * (3 - (i % 4)));
    return v;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_ref);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk_ref);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_ref);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_ref);
  endtask

  task automatic t_reset_R1();
    logic [31:0] d;
    chk("R1 mode after reset", 32'(mode_o), 7);
    chk("R1 minw after reset", 32'(minw_o), 0);
    chk("R1 irq after reset", 32'(irq_o), 0);
    rd(3'd4, d);
    chk("R1 threshold word after reset", d, 0);
  endtask

  task automatic t_pack_R6_R7();
    logic [31:0] d;
    wr(3'd2, tmr_word(0)); wr(3'd3, tmr_word(1));
    wr(3'd4, thr_word(0)); wr(3'd5, thr_word(1));
    rd(3'd2, d); chk("R7 timer word 0", d, tmr_word(0));
    rd(3'd3, d); chk("R7 timer word 1", d, tmr_word(1));
    rd(3'd4, d); chk("R6 threshold word 0", d, thr_word(0));
    rd(3'd5, d); chk("R6 threshold word 1", d, thr_word(1));
  endtask

  task automatic t_disabled_R10();
    half_a = 60; half_b = 60;
    wr(3'd1, {4'h0, 8'h04, 20'(WIN)});
    wait_cyc(3 * WIN);
    chk("R10 mode held while disabled", 32'(mode_o), 7);
    chk("R10 minw held while disabled", 32'(minw_o), 0);
  endtask

  task automatic t_rate_step(input int h);
    half_a = h; half_b = h;
    wait_cyc(3 * WIN + 10);
    chk($sformatf("R2 R3 mode for interval %0d", h), 32'(mode_o), 32'(exp_mode(h)));
    chk($sformatf("R5 minw for interval %0d", h), 32'(minw_o), 32'(h));
    chk($sformatf("R8 R9 irq after change to %0d", h), 32'(irq_o), 1);
    wr(3'd6, 32'h4);
    chk("R8 irq cleared by write-one", 32'(irq_o), 0);
  endtask

  task automatic t_sweep_R2_R3();
    wr(3'd0, 32'h1);
    t_rate_step(60);  // mode 0
    t_rate_step(44);  // mode 1
    t_rate_step(40);  // mode 2
    t_rate_step(22);  // mode 3
    t_rate_step(20);  // mode 4
    t_rate_step(11);  // mode 5
    t_rate_step(10);  // R3: no threshold met, mode 6
    t_rate_step(42);  // R2: 84 equals threshold 1 exactly
    t_rate_step(41);  // R2: 82 just below threshold 1
  endtask

  task automatic t_no_change_R8();
    wait_cyc(2 * WIN);
    chk("R8 no irq with unchanged mode", 32'(irq_o), 0);
    chk("R8 mode still 2", 32'(mode_o), 2);
  endtask

  task automatic t_mixed_R5();
    half_a = 22; half_b = 50;
    wait_cyc(3 * WIN + 10);
    chk("R5 minimum of mixed 22/50 pattern", 32'(minw_o), 22);
    chk("R2 mode of mixed pattern", 32'(mode_o), 3);
    wr(3'd6, 32'h4);
  endtask

  task automatic t_mask_R9();
    logic [31:0] d;
    wr(3'd1, {4'h0, 8'h00, 20'(WIN)});
    half_a = 20; half_b = 20;
    wait_cyc(3 * WIN + 10);
    chk("R9 irq masked", 32'(irq_o), 0);
    rd(3'd6, d);
    chk("R8 status bit 2 set while masked", d, 32'h4);
    wr(3'd6, 32'h4);
    rd(3'd6, d);
    chk("R8 status cleared", d, 0);
  endtask

  task automatic t_nosignal_R4();
    half_a = 0; half_b = 0;
    wait_cyc(3 * WIN + 10);
    chk("R4 minw with no edges", 32'(minw_o), 0);
    chk("R4 mode with no edges", 32'(mode_o), 7);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk_ref);
    n_chk++; n_bad++;
    $display("FAIL watchdog all requirements act=timeout exp=completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset_R1();
    t_pack_R6_R7();
    t_disabled_R10();
    t_sweep_R2_R3();
    t_no_change_R8();
    t_mixed_R5();
    t_mask_R9();
    t_nosignal_R4();
    summary();
    $finish;
  end
endmodule